// File: doc/BRIEF.md
# Serial Clock Lane Sequencer

This block is the transmit-side controller for the clock lane of a source-synchronous serial link. It steps the lane through its low-power and high-speed line states. These are a stop level, a request level and a bridge level, then a driven high-speed zero, then a toggling high-speed clock, which is later wound back down through a trailing zero and a stop period. Every interval is a cycle count taken from a configuration input and counted in the single controller clock domain.

A burst begins with a valid/ready request. The request may be held high for any length of time: while `req_ready` is low the request waits and nothing is consumed. Once the clock has toggled for its lead time, the block raises `data_go` to tell the data lanes they may start their own high-speed entry. It keeps the clock running until the data lanes report that the last of them has returned to low power. The clock then runs for a programmed tail, trails, and parks the lane in the stop state for a programmed exit time before the next request can be taken. All timing inputs are captured when a request is accepted, and a zero count is treated as one cycle.

Top module: `clk_lane_seq`

## Requirements
- R1: During and right after reset, `lane_code` is 0 (stop), `lp_pn` is 2'b11, `hs_en` and `clk_run` are 0, `data_go` is 0 and `req_ready` is 1.
- R2: The line pins follow `lane_code`. Code 0 (stop) gives `lp_pn`=11. Code 1 (request) gives `lp_pn`=01, meaning P low and N high, with bit 1 as P. Code 2 (bridge) gives `lp_pn`=00. In all three the high-speed pins are off. Code 3 (HS zero) gives `lp_pn`=00, `hs_en`=1 and `clk_run`=0. Code 4 (toggling) gives `lp_pn`=00, `hs_en`=1 and `clk_run`=1.
- R3: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the lane is idle. All seven timing inputs are captured on that edge, and later changes have no effect on the burst in progress.
- R4: After acceptance, the lane shows stop for `cfg_lpx` cycles, then request for `cfg_lpx` cycles, then bridge for the larger of `cfg_prep` and `cfg_lpx` cycles.
- R5: After the bridge, the lane drives HS zero for `cfg_zero` cycles, then starts toggling.
- R6: `data_go` rises after exactly `cfg_pre` toggling cycles. It stays high, with the clock toggling, until `data_done` is sampled high.
- R7: `data_done` has no effect while `data_go` is low.
- R8: After `data_done` is sampled with `data_go` high, `data_go` drops and the clock toggles for `cfg_post` more cycles. HS zero is then driven for `cfg_trail` cycles. Stop is then held for `cfg_exit` cycles with `req_ready` low, after which `req_ready` returns high.
- R9: A timing input of zero is counted as one cycle.
- R10: A request held high across a burst is accepted on the first edge where `req_ready` is high, so `req_ready` is seen for exactly one cycle between the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request |
| req_ready | output | 1 | Lane idle, request can be taken |
| cfg_lpx | input | TW | Low-power state period, cycles |
| cfg_prep | input | TW | Bridge (prepare) time, cycles |
| cfg_zero | input | TW | HS zero before clock start, cycles |
| cfg_pre | input | TW | Clock lead before data entry, cycles |
| cfg_post | input | TW | Clock tail after data done, cycles |
| cfg_trail | input | TW | HS zero after last clock, cycles |
| cfg_exit | input | TW | Stop hold after trail, cycles |
| data_go | output | 1 | Data lanes may enter high speed |
| data_done | input | 1 | Last data lane is back in low power |
| lane_code | output | 3 | Current line state code |
| lp_pn | output | 2 | Low-power driver levels, bit 1 = P |
| hs_en | output | 1 | High-speed driver enabled |
| clk_run | output | 1 | High-speed clock toggling |

## Verification
The assertions take for granted that `data_done` comes from data lanes that only report completion after they were released. They also assume the timing inputs are stable whenever a request could be taken. The bench pulses `data_done` once while the clock is still in its lead phase, where it must be ignored. It otherwise raises `data_done` only after `data_go` has been seen. It changes the timing inputs only after the accepting edge or while the lane is busy. The same stimulus also checks that the captured values win.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LP11, ST_LP01, ST_LP00, ST_ZERO,
    ST_PRE, ST_RUN, ST_POST, ST_TRAIL, ST_EXIT
  } seq_state_e;

  typedef enum logic [2:0] {
    LINE_STOP   = 3'd0,
    LINE_REQ    = 3'd1,
    LINE_BRIDGE = 3'd2,
    LINE_HS0    = 3'd3,
    LINE_HSCLK  = 3'd4
  } line_code_e;

  localparam int NUM_TIMERS = 7;
  localparam int T_LPX   = 0;
  localparam int T_PREP  = 1;
  localparam int T_ZERO  = 2;
  localparam int T_PRE   = 3;
  localparam int T_POST  = 4;
  localparam int T_TRAIL = 5;
  localparam int T_EXIT  = 6;

endpackage

// File: rtl/clk_lane_cfg.sv
// Captures timing fields at burst acceptance; zero clamps to one.
// While capture is high the clamped live values are passed through.
module clk_lane_cfg #(
  parameter int W = 8,
  parameter int N = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [N-1:0][W-1:0] raw,
  output logic [N-1:0][W-1:0] eff
);
  localparam logic [W-1:0] ONE = W'(1);

  for (genvar i = 0; i < N; i++) begin : g_field
    logic [W-1:0] clamped;
    logic [W-1:0] held_q;

    assign clamped = (raw[i] == '0) ? ONE : raw[i];

    always_ff @(posedge clk) begin
      if (!rst_n)       held_q <= ONE;
      else if (capture) held_q <= clamped;
    end

    assign eff[i] = capture ? clamped : held_q;
  end
endmodule

// File: rtl/clk_lane_timer.sv
// Interval counter: after a load of len (>=1), expired is high in the
// len-th cycle of the interval.
module clk_lane_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= len - W'(1);
    else if (cnt_q != 0) cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/clk_lane_enc.sv
// Maps the sequencer state onto line codes and driver controls.
module clk_lane_enc
  import clk_lane_pkg::*;
(
  input  seq_state_e st,
  output logic [2:0] code,
  output logic [1:0] lp_pn,
  output logic       hs_en,
  output logic       clk_run,
  output logic       data_go,
  output logic       req_ready
);
  line_code_e c;

  always_comb begin
    unique case (st)
      ST_LP01:                c = LINE_REQ;
      ST_LP00:                c = LINE_BRIDGE;
      ST_ZERO, ST_TRAIL:      c = LINE_HS0;
      ST_PRE, ST_RUN, ST_POST: c = LINE_HSCLK;
      default:                c = LINE_STOP;
    endcase
  end

  always_comb begin
    lp_pn   = 2'b00;
    hs_en   = 1'b0;
    clk_run = 1'b0;
    unique case (c)
      LINE_STOP:   lp_pn = 2'b11;
      LINE_REQ:    lp_pn = 2'b01;
      LINE_BRIDGE: lp_pn = 2'b00;
      LINE_HS0:    hs_en = 1'b1;
      LINE_HSCLK:  begin hs_en = 1'b1; clk_run = 1'b1; end
      default:     lp_pn = 2'b11;
    endcase
  end

  assign code      = c;
  assign data_go   = (st == ST_RUN);
  assign req_ready = (st == ST_IDLE);
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [TW-1:0] cfg_lpx,
  input  logic [TW-1:0] cfg_prep,
  input  logic [TW-1:0] cfg_zero,
  input  logic [TW-1:0] cfg_pre,
  input  logic [TW-1:0] cfg_post,
  input  logic [TW-1:0] cfg_trail,
  input  logic [TW-1:0] cfg_exit,
  output logic          data_go,
  input  logic          data_done,
  output logic [2:0]    lane_code,
  output logic [1:0]    lp_pn,
  output logic          hs_en,
  output logic          clk_run
);
  localparam int NT = NUM_TIMERS;

  seq_state_e state_q, state_nx;
  logic [NT-1:0][TW-1:0] raw, eff;
  logic [TW-1:0] bridge_len, load_len;
  logic accept, advance, expired;

  assign raw[T_LPX]   = cfg_lpx;
  assign raw[T_PREP]  = cfg_prep;
  assign raw[T_ZERO]  = cfg_zero;
  assign raw[T_PRE]   = cfg_pre;
  assign raw[T_POST]  = cfg_post;
  assign raw[T_TRAIL] = cfg_trail;
  assign raw[T_EXIT]  = cfg_exit;

  assign accept = (state_q == ST_IDLE) && req_valid;

  clk_lane_cfg #(.W(TW), .N(NT)) cfg_i (
    .clk(clk), .rst_n(rst_n), .capture(accept), .raw(raw), .eff(eff)
  );

  // bridge must satisfy both the prepare time and the LP minimum
  assign bridge_len = (eff[T_PREP] > eff[T_LPX]) ? eff[T_PREP] : eff[T_LPX];

  always_comb begin
    unique case (state_q)
      ST_IDLE:  state_nx = ST_LP11;
      ST_LP11:  state_nx = ST_LP01;
      ST_LP01:  state_nx = ST_LP00;
      ST_LP00:  state_nx = ST_ZERO;
      ST_ZERO:  state_nx = ST_PRE;
      ST_PRE:   state_nx = ST_RUN;
      ST_RUN:   state_nx = ST_POST;
      ST_POST:  state_nx = ST_TRAIL;
      ST_TRAIL: state_nx = ST_EXIT;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: advance = req_valid;
      ST_RUN:  advance = data_done;
      default: advance = expired;
    endcase
  end

  always_comb begin
    unique case (state_nx)
      ST_LP11, ST_LP01: load_len = eff[T_LPX];
      ST_LP00:          load_len = bridge_len;
      ST_ZERO:          load_len = eff[T_ZERO];
      ST_PRE:           load_len = eff[T_PRE];
      ST_POST:          load_len = eff[T_POST];
      ST_TRAIL:         load_len = eff[T_TRAIL];
      ST_EXIT:          load_len = eff[T_EXIT];
      default:          load_len = TW'(1);
    endcase
  end

  clk_lane_timer #(.W(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(advance), .len(load_len), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= ST_IDLE;
    else if (advance) state_q <= state_nx;
  end

  clk_lane_enc enc_i (
    .st(state_q), .code(lane_code), .lp_pn(lp_pn), .hs_en(hs_en),
    .clk_run(clk_run), .data_go(data_go), .req_ready(req_ready)
  );
endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       data_go,
  input logic       data_done,
  input logic [2:0] lane_code,
  input logic [1:0] lp_pn,
  input logic       hs_en,
  input logic       clk_run
);
  // R2
  hs_lp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (lp_pn == 2'b00));

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lane_code == 3'd0 && !hs_en && !data_go));

  // R4
  req_to_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_code == 3'd1) |=> (lane_code inside {3'd1, 3'd2}));

  // R4
  bridge_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_code == 3'd2) |=> (lane_code inside {3'd2, 3'd3}));

  // R5
  clk_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_run) |-> ($past(lane_code) == 3'd3));

  // R6
  go_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |-> clk_run);

  // R8
  tail_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_go) |-> clk_run);

  // R8
  trail_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_run) |-> (lane_code == 3'd3));

  // R10
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  done_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !data_go && clk_run) |=> clk_run);
endmodule

bind clk_lane_seq clk_lane_seq_chk chk_i (.*);

// File: tb/clk_lane_seq_tb_top.sv
module clk_lane_seq_tb_top;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic data_done = 1'b0;
  logic [TW-1:0] cfg_lpx = '0, cfg_prep = '0, cfg_zero = '0, cfg_pre = '0;
  logic [TW-1:0] cfg_post = '0, cfg_trail = '0, cfg_exit = '0;
  logic req_ready, data_go, hs_en, clk_run;
  logic [2:0] lane_code;
  logic [1:0] lp_pn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int seg [0:15];
  int nseg;
  int pin_bad;

  always #2 clk = ~clk;

  clk_lane_seq #(.TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_trail(cfg_trail),
    .cfg_exit(cfg_exit), .data_go(data_go), .data_done(data_done),
    .lane_code(lane_code), .lp_pn(lp_pn), .hs_en(hs_en), .clk_run(clk_run)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_cfg(input int a, b, c, d, e, f, g);
    cfg_lpx = TW'(a); cfg_prep = TW'(b); cfg_zero = TW'(c); cfg_pre = TW'(d);
    cfg_post = TW'(e); cfg_trail = TW'(f); cfg_exit = TW'(g);
  endtask

  // pin pattern expected for each line code (R2)
  function automatic bit pins_ok();
    case (lane_code)
      3'd0: return lp_pn == 2'b11 && !hs_en && !clk_run;
      3'd1: return lp_pn == 2'b01 && !hs_en && !clk_run;
      3'd2: return lp_pn == 2'b00 && !hs_en && !clk_run;
      3'd3: return lp_pn == 2'b00 && hs_en && !clk_run;
      3'd4: return lp_pn == 2'b00 && hs_en && clk_run;
      default: return 1'b0;
    endcase
  endfunction

  // Runs one burst, recording run lengths of {code, ready, go}.
  task automatic run_burst(input int w, input bit pre_acc, input bit hold,
                           input bit early, input bit chg);
    int key, prev, runcnt, guard;
    bit early_sent;
    if (!pre_acc) begin
      @(negedge clk);
      req_valid = 1'b1;
      chk(req_ready == 1'b1, "R3 ready before request", req_ready, 1);
    end
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    if (chg) set_cfg(20, 20, 20, 20, 20, 20, 20);
    nseg = 0; seg[0] = 0; prev = -1; runcnt = 0; early_sent = 0; guard = 0;
    while (!req_ready && guard < 5000) begin
      if (!pins_ok()) pin_bad++;
      key = {lane_code, req_ready, data_go};
      if (prev < 0) seg[0] = 1;
      else if (key == prev) seg[nseg]++;
      else if (nseg < 15) begin nseg++; seg[nseg] = 1; end
      prev = key;
      data_done = 1'b0;
      if (data_go) begin
        runcnt++;
        if (runcnt == w) data_done = 1'b1;
      end else if (early && lane_code == 3'd4 && !early_sent) begin
        data_done = 1'b1;
        early_sent = 1;
      end
      guard++;
      @(negedge clk);
    end
    data_done = 1'b0;
  endtask

  task automatic verify(input int a, b, c, d, e, f, g, w);
    int br;
    br = (cl(b) > cl(a)) ? cl(b) : cl(a);
    chk(nseg == 8, "R8 phase count", nseg + 1, 9);
    chk(seg[0] == cl(a), "R4 stop hold", seg[0], cl(a));
    chk(seg[1] == cl(a), "R4 request hold", seg[1], cl(a));
    chk(seg[2] == br, "R4 bridge hold", seg[2], br);
    chk(seg[3] == cl(c), "R5 HS zero", seg[3], cl(c));
    chk(seg[4] == cl(d), "R6 clock lead", seg[4], cl(d));
    chk(seg[5] == w, "R6 data_go span", seg[5], w);
    chk(seg[6] == cl(e), "R8 clock tail", seg[6], cl(e));
    chk(seg[7] == cl(f), "R8 trail", seg[7], cl(f));
    chk(seg[8] == cl(g), "R8 exit hold", seg[8], cl(g));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(lane_code == 3'd0, "R1 code", lane_code, 0);
    chk(lp_pn == 2'b11, "R1 lp_pn", lp_pn, 3);
    chk(!hs_en && !clk_run, "R1 hs off", {hs_en, clk_run}, 0);
    chk(!data_go, "R1 data_go", data_go, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_basic();
    set_cfg(3, 5, 4, 2, 6, 3, 5);
    pin_bad = 0;
    run_burst(3, 0, 0, 0, 0);
    verify(3, 5, 4, 2, 6, 3, 5, 3);
    chk(pin_bad == 0, "R2 pins per code", pin_bad, 0);
  endtask

  task automatic t_second();
    set_cfg(6, 2, 1, 9, 13, 7, 2);
    pin_bad = 0;
    run_burst(1, 0, 0, 0, 0);
    verify(6, 2, 1, 9, 13, 7, 2, 1);
    chk(pin_bad == 0, "R2 pins per code", pin_bad, 0);
  endtask

  task automatic t_clamp();
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    run_burst(2, 0, 0, 0, 0);
    verify(0, 0, 0, 0, 0, 0, 0, 2);
    chk(seg[4] == 1, "R9 zero lead clamps to one", seg[4], 1);
  endtask

  task automatic t_capture();
    set_cfg(3, 5, 4, 2, 6, 3, 5);
    run_burst(2, 0, 0, 0, 1);
    verify(3, 5, 4, 2, 6, 3, 5, 2);
    chk(seg[6] == 6, "R3 tail uses captured value", seg[6], 6);
  endtask

  task automatic t_early();
    set_cfg(2, 3, 2, 4, 3, 2, 3);
    run_burst(2, 0, 0, 1, 0);
    verify(2, 3, 2, 4, 3, 2, 3, 2);
    chk(seg[4] == 4, "R7 early done ignored", seg[4], 4);
  endtask

  task automatic t_b2b();
    set_cfg(4, 2, 2, 3, 2, 2, 3);
    run_burst(1, 0, 1, 0, 0);
    verify(4, 2, 2, 3, 2, 2, 3, 1);
    chk(req_ready == 1'b1, "R10 ready between bursts", req_ready, 1);
    run_burst(2, 1, 0, 0, 0);
    chk(seg[0] == 4, "R10 held request taken at once", seg[0], 4);
    verify(4, 2, 2, 3, 2, 2, 3, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_second();
    t_clamp();
    t_capture();
    t_early();
    t_b2b();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule